// File: doc/BRIEF.md
# Four-Phase Fetch/Execute Pipeline Sequencer

This block turns a fast oscillator clock into a sequence of instruction cycles. Each cycle is four oscillator periods long, and a single one-hot phase strobe names which of the four phases is active. The sequencer owns the program counter, a fetch holding register and the instruction register. The next instruction is fetched while the current one executes, so a straight-line instruction finishes in one instruction cycle.

Data-memory read and write strobes come out at fixed phases. A clock-out runs at one quarter of the oscillator rate. A neighbouring decoder reports a taken branch and its target. The sequencer then loads the target into the program counter and discards the word that was fetched alongside the branch. That slot executes as a forced no-op, so a taken branch costs two instruction cycles. Program memory, data memory, the ALU and full decode sit outside the block and meet it at ports.

Top module: `qpipe_seq`

## Requirements
- R1: `q_strobe` is one-hot on every oscillator cycle: bit 0 is phase 1, bit 1 is phase 2, bit 2 is phase 3 and bit 3 is phase 4.
- R2: The phases advance one per oscillator cycle in the order 1, 2, 3, 4 and then back to 1.
- R3: `prog_addr` changes only at the start of phase 1. Without a taken branch it increases by one, modulo 2^ADDR_W.
- R4: `prog_word` is sampled at the clock edge that enters phase 4. Unless the cycle is flushed, that word appears on `ir_word` from the next phase 1 through that cycle's phase 4.
- R5: `dm_rd` is high only in phase 2. `dm_wr` is high only in phase 4, and only when the current instruction is not a forced no-op.
- R6: `clk_out` is high in phases 1 and 2 and low in phases 3 and 4.
- R7: A synchronous reset puts the block in phase 1 with `prog_addr` = 0, `ir_word` = 0 (the no-op encoding is all zeros) and `exec_nop` = 1. The word at address 0 therefore executes in the second instruction cycle.
- R8: `br_take` is sampled only at the edge that ends phase 4. When it is taken, `br_target` becomes `prog_addr` at the next phase 1, and for that cycle `ir_word` is 0 and `exec_nop` is 1. A `br_take` pulse that has gone low by the end of phase 4 has no effect.
- R9: During a cycle that executes a forced no-op, `br_take` is ignored and the program counter steps by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_word | input | WORD_W | Word read from program memory at `prog_addr` |
| br_take | input | 1 | Decoder flag: the executing instruction redirects the program counter |
| br_target | input | ADDR_W | Redirect address |
| q_strobe | output | 4 | One-hot phase strobes, phase 1 in bit 0 |
| clk_out | output | 1 | Oscillator divided by four |
| prog_addr | output | ADDR_W | Program counter, the fetch address |
| ir_word | output | WORD_W | Instruction currently executing |
| exec_nop | output | 1 | The current instruction is a forced no-op |
| dm_rd | output | 1 | Data-memory operand read strobe |
| dm_wr | output | 1 | Data-memory destination write strobe |

## Verification
The bench aims at the branch slot. An off-by-one in the flush would run the stale fetched word, or would redirect one cycle late so that target+1 showed up first. A write strobe that fires in the flushed slot would corrupt data memory. The bench tries a branch whose flag is withdrawn before phase 4; a design that samples too early would jump anyway. It also tries a branch flag during a flushed slot, where a design that honours it would take a phantom jump. Further checks cover the counter wrapping at the top of the address space and a reset landing in the middle of a cycle, where a design that kept the old phase would misalign every later strobe.

// File: rtl/qpipe_pkg.sv
package qpipe_pkg;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_t;

    localparam int NUM_PHASES = 4;

    function automatic phase_t phase_next(input phase_t p);
        phase_t n;
        case (p)
            PH_Q1:   n = PH_Q2;
            PH_Q2:   n = PH_Q3;
            PH_Q3:   n = PH_Q4;
            default: n = PH_Q1;
        endcase
        return n;
    endfunction

    // Control decoded from the current phase, shared by the sub-units
    typedef struct packed {
        logic capture;   // edge entering phase 4: latch program word
        logic advance;   // edge leaving phase 4: new cycle begins
        logic rd_phase;  // phase 2
        logic wr_phase;  // phase 4
    } phase_ctl_t;

endpackage

// File: rtl/qpipe_phase_gen.sv
module qpipe_phase_gen
    import qpipe_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    output logic [NUM_PHASES-1:0] q_strobe,
    output logic                  clk_out,
    output phase_ctl_t            ctl
);

    phase_t ph_q;

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_Q1;
        else     ph_q <= phase_next(ph_q);
    end

    for (genvar i = 0; i < NUM_PHASES; i++) begin : g_strobe
        assign q_strobe[i] = (ph_q == phase_t'(i));
    end

    assign clk_out      = (ph_q == PH_Q1) || (ph_q == PH_Q2);
    assign ctl.capture  = (ph_q == PH_Q3);
    assign ctl.advance  = (ph_q == PH_Q4);
    assign ctl.rd_phase = (ph_q == PH_Q2);
    assign ctl.wr_phase = (ph_q == PH_Q4);

endmodule

// File: rtl/qpipe_fetch.sv
module qpipe_fetch
    import qpipe_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_ctl_t        ctl,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] target,
    input  logic [WORD_W-1:0] prog_word,
    output logic [ADDR_W-1:0] pc,
    output logic [WORD_W-1:0] fetched
);

    localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc      <= '0;
            fetched <= '0;
        end else begin
            if (ctl.capture) fetched <= prog_word;
            if (ctl.advance) pc <= redirect ? target : pc + PC_ONE;
        end
    end

endmodule

// File: rtl/qpipe_exec.sv
module qpipe_exec
    import qpipe_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_ctl_t        ctl,
    input  logic              br_take,
    input  logic [WORD_W-1:0] fetched,
    output logic              redirect,
    output logic [WORD_W-1:0] ir,
    output logic              squash,
    output logic              dm_rd,
    output logic              dm_wr
);

    localparam logic [WORD_W-1:0] NOP_WORD = '0;

    // A forced no-op cannot branch
    assign redirect = br_take && !squash;

    always_ff @(posedge clk) begin
        if (rst) begin
            ir     <= NOP_WORD;
            squash <= 1'b1;
        end else if (ctl.advance) begin
            ir     <= redirect ? NOP_WORD : fetched;
            squash <= redirect;
        end
    end

    assign dm_rd = ctl.rd_phase;
    assign dm_wr = ctl.wr_phase && !squash;

endmodule

// File: rtl/qpipe_seq.sv
module qpipe_seq
    import qpipe_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] prog_word,
    input  logic              br_take,
    input  logic [ADDR_W-1:0] br_target,
    output logic [3:0]        q_strobe,
    output logic              clk_out,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [WORD_W-1:0] ir_word,
    output logic              exec_nop,
    output logic              dm_rd,
    output logic              dm_wr
);

    phase_ctl_t        ctl;
    logic              redirect;
    logic [WORD_W-1:0] fetched;

    qpipe_phase_gen u_phase (
        .clk      (clk),
        .rst      (rst),
        .q_strobe (q_strobe),
        .clk_out  (clk_out),
        .ctl      (ctl)
    );

    qpipe_fetch #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .redirect  (redirect),
        .target    (br_target),
        .prog_word (prog_word),
        .pc        (prog_addr),
        .fetched   (fetched)
    );

    qpipe_exec #(.WORD_W(WORD_W)) u_exec (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .br_take  (br_take),
        .fetched  (fetched),
        .redirect (redirect),
        .ir       (ir_word),
        .squash   (exec_nop),
        .dm_rd    (dm_rd),
        .dm_wr    (dm_wr)
    );

endmodule

// File: rtl/qpipe_seq_chk.sv
module qpipe_seq_chk #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] prog_word,
    input logic              br_take,
    input logic [ADDR_W-1:0] br_target,
    input logic [3:0]        q_strobe,
    input logic              clk_out,
    input logic [ADDR_W-1:0] prog_addr,
    input logic [WORD_W-1:0] ir_word,
    input logic              exec_nop,
    input logic              dm_rd,
    input logic              dm_wr
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (rst) $countones(q_strobe) == 1); // R1
    AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (rst) q_strobe[0] |=> q_strobe[1]); // R2
    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst) q_strobe[3] |=> q_strobe[0]); // R2
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst) !q_strobe[3] |=> $stable(prog_addr)); // R3
    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst) (q_strobe[3] && !(br_take && !exec_nop)) |=> prog_addr == $past(prog_addr) + ONE); // R3
    AST_IR_LOAD: assert property (@(posedge clk) disable iff (rst) (q_strobe[0] && !exec_nop) |-> ir_word == $past(prog_word, 2)); // R4
    AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst) !q_strobe[3] |=> $stable(ir_word)); // R4
    AST_RD_PHASE: assert property (@(posedge clk) disable iff (rst) dm_rd |-> q_strobe[1]); // R5
    AST_WR_PHASE: assert property (@(posedge clk) disable iff (rst) dm_wr |-> (q_strobe[3] && !exec_nop)); // R5
    AST_CLKOUT_FALL: assert property (@(posedge clk) disable iff (rst) q_strobe[1] |=> !clk_out); // R6
    AST_CLKOUT_RISE: assert property (@(posedge clk) disable iff (rst) q_strobe[3] |=> clk_out); // R6
    AST_BR_REDIRECT: assert property (@(posedge clk) disable iff (rst) (q_strobe[3] && br_take && !exec_nop) |=> (prog_addr == $past(br_target) && exec_nop && ir_word == '0)); // R8
    AST_NOP_NO_BRANCH: assert property (@(posedge clk) disable iff (rst) (q_strobe[3] && exec_nop) |=> !exec_nop); // R9

endmodule

bind qpipe_seq qpipe_seq_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/sim_qpipe_seq.sv
module sim_qpipe_seq;

    localparam int AW = 8;
    localparam int WW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [WW-1:0] prog_word;
    logic          br_take = 1'b0;
    logic [AW-1:0] br_target = '0;
    logic [3:0]    q_strobe;
    logic          clk_out;
    logic [AW-1:0] prog_addr;
    logic [WW-1:0] ir_word;
    logic          exec_nop;
    logic          dm_rd;
    logic          dm_wr;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    function automatic logic [WW-1:0] w(input logic [AW-1:0] a);
        return {8'hC3, a};
    endfunction

    // program memory model
    assign prog_word = w(prog_addr);

    qpipe_seq #(.ADDR_W(AW), .WORD_W(WW)) u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Runs one instruction cycle from a Q1 negedge; checks every phase
    task automatic run_cycle(input logic take, input logic [AW-1:0] tgt,
                             input logic [AW-1:0] exp_pc, input logic [WW-1:0] exp_ir,
                             input logic exp_sq, input logic drop_at_q4);
        br_take   = take;
        br_target = tgt;
        for (int p = 0; p < 4; p++) begin
            if (p == 3 && drop_at_q4) br_take = 1'b0;
            check("R1 strobe", 32'(q_strobe), 32'(4'b0001 << p));
            check("R6 clk_out", 32'(clk_out), 32'(p < 2));
            check("R5 dm_rd", 32'(dm_rd), 32'(p == 1));
            check("R5 dm_wr", 32'(dm_wr), 32'(p == 3 && !exp_sq));
            check("R3 pc", 32'(prog_addr), 32'(exp_pc));
            check("R4 R8 ir", 32'(ir_word), 32'(exp_ir));
            check("R8 R9 nop", 32'(exec_nop), 32'(exp_sq));
            @(negedge clk);
        end
        br_take = 1'b0;
    endtask

    // take, target, expected pc, expected ir, expected nop
    localparam int NV = 12;
    localparam logic [33:0] VEC [NV] = '{
        {1'b0, 8'h00, 8'h00, 16'h0000, 1'b1},  // R7 first cycle after reset
        {1'b0, 8'h00, 8'h01, 16'hC300, 1'b0},
        {1'b1, 8'h40, 8'h02, 16'hC301, 1'b0},  // R8 branch taken
        {1'b0, 8'h00, 8'h40, 16'h0000, 1'b1},
        {1'b0, 8'h00, 8'h41, 16'hC340, 1'b0},
        {1'b1, 8'hFE, 8'h42, 16'hC341, 1'b0},
        {1'b0, 8'h00, 8'hFE, 16'h0000, 1'b1},
        {1'b0, 8'h00, 8'hFF, 16'hC3FE, 1'b0},
        {1'b1, 8'h10, 8'h00, 16'hC3FF, 1'b0},  // R3 wrap to zero
        {1'b1, 8'h20, 8'h10, 16'h0000, 1'b1},  // R9 ignored in flushed slot
        {1'b0, 8'h00, 8'h11, 16'hC310, 1'b0},
        {1'b0, 8'h00, 8'h12, 16'hC311, 1'b0}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            run_cycle(VEC[i][33], VEC[i][32:25], VEC[i][24:17], VEC[i][16:1], VEC[i][0], 1'b0);
        end
        // R8: flag withdrawn before phase 4 has no effect
        run_cycle(1'b1, 8'h77, 8'h13, 16'hC312, 1'b0, 1'b1);
        run_cycle(1'b0, 8'h00, 8'h14, 16'hC313, 1'b0, 1'b0);
        // R7: reset in the middle of a cycle
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R7 strobe", 32'(q_strobe), 32'h1);
        check("R7 pc", 32'(prog_addr), 32'h0);
        check("R7 ir", 32'(ir_word), 32'h0);
        check("R7 nop", 32'(exec_nop), 32'h1);
        check("R7 clk_out", 32'(clk_out), 32'h1);
        rst = 1'b0;
        run_cycle(1'b0, 8'h00, 8'h00, 16'h0000, 1'b1, 1'b0);
        run_cycle(1'b0, 8'h00, 8'h01, 16'hC300, 1'b0, 1'b0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule